// File: doc/BRIEF.md
# Nonvolatile Shadow Copy Controller

This block decides when the contents of a volatile SRAM array are copied into their nonvolatile shadow, and when they are copied back. A copy into the shadow (a store) can start in two ways. One is an external agent pulling a shared open-drain busy/request line low. The other is a one-cycle software store pulse from a command detector. A copy back (a recall) starts from a software recall pulse or by itself when the supply recovers from a low condition. The controller sequences each operation through timed phases. A store erases the shadow and then programs it. A recall clears the SRAM and then loads the shadow data into it.

The same line carries requests in and busy status out. The controller drives it low through a pull-low enable for as long as any operation runs. After the operation it lets go and keeps the SRAM disabled until the line reads high again. A dirty latch records whether the SRAM has been written since the last completed copy. Requests from the line only lead to a store when that latch is set. When the latch is clear, a request only blocks SRAM access until the line is released. A single down-counter, loaded from a parameter, times the holdoff delay and each phase. The active state is exposed as a one-hot vector.

Top module: `nvshadow_arbiter`

## Requirements
- R1: While reset is held, the state vector is the power-loss state (bit 8 of `stateOneHot`), both `readInhibit` and `writeInhibit` are 1, and `pinPullLow` is 0.
- R2: From the power-loss state with `powerGood` high, a recall runs automatically. The clear state (bit 4) lasts CLEAR_CYC cycles and the load state (bit 5) lasts LOAD_CYC cycles. During both, `pinPullLow`, `readInhibit` and `writeInhibit` are 1.
- R3: When `powerGood` is sampled low in any state, the next state is the power-loss state and any running operation is abandoned.
- R4: The dirty latch is set only by an `sramWrite` sampled while `writeInhibit` is 0. It is cleared when the last phase of a store or recall ends. A write attempted during the holdoff leaves it clear after that store.
- R5: In idle (bit 0), a low line with the latch set enters the holdoff state (bit 1) for HOLD_CYC cycles. In holdoff, reads stay allowed, writes are blocked and the line is pulled low. The store then runs through erase (bit 2) for ERASE_CYC cycles and program (bit 3) for PROG_CYC cycles, with the line pulled low.
- R6: In idle, a low line with the latch clear enters the blocked state (bit 7). There `pinPullLow` is 0 and both inhibits are 1 until the line is sampled high.
- R7: A `swStore` pulse in idle runs erase then program whether or not the latch is set.
- R8: A `swRecall` pulse in idle runs clear then load.
- R9: After program or load ends, the release state (bit 6) holds with `pinPullLow` 0 and both inhibits 1, and returns to idle on the first cycle the line is sampled high.
- R10: In idle the request priority is: low supply first, then a low line, then `swStore`, then `swRecall`.
- R11: `swStore` or `swRecall` pulses arriving outside idle are ignored and not queued.
- R12: `stateOneHot` has exactly one bit set. Each of `eraseEn`, `programEn`, `clearEn` and `loadEn` is 1 exactly in its own phase state (bits 2, 3, 4 and 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Sensed level of the shared open-drain request/busy line |
| powerGood | input | 1 | Supply above threshold |
| sramWrite | input | 1 | SRAM write request strobe |
| swStore | input | 1 | Software store command pulse |
| swRecall | input | 1 | Software recall command pulse |
| pinPullLow | output | 1 | Enable for the open-drain pull-down on the line |
| readInhibit | output | 1 | Block SRAM reads |
| writeInhibit | output | 1 | Block SRAM writes |
| eraseEn | output | 1 | Shadow erase phase strobe |
| programEn | output | 1 | Shadow program phase strobe |
| clearEn | output | 1 | SRAM clear phase strobe |
| loadEn | output | 1 | Shadow-to-SRAM transfer phase strobe |
| stateOneHot | output | 9 | One-hot state vector |

## Verification
The main flow is exercised with the line request under a set and a clear dirty latch. This separates a conditional store from a plain access block. Software store is tried with the latch clear and set to show it is unconditional, and software recall follows to show it clears the latch. Simultaneous requests show the priority order. Writes and software pulses injected mid-operation show they are ignored, and a supply drop in mid-erase shows the abort and the automatic recall.

// File: rtl/nvsc_pkg.sv
package nvsc_pkg;

  localparam int NUM_ST = 9;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_HOLDOFF = 4'd1,
    ST_ERASE   = 4'd2,
    ST_PROGRAM = 4'd3,
    ST_CLEAR   = 4'd4,
    ST_LOAD    = 4'd5,
    ST_RELEASE = 4'd6,
    ST_BLOCKED = 4'd7,
    ST_PWRLOSS = 4'd8
  } ctlState_t;

  typedef enum logic [2:0] {
    DUR_HOLD  = 3'd0,
    DUR_ERASE = 3'd1,
    DUR_PROG  = 3'd2,
    DUR_CLEAR = 3'd3,
    DUR_LOAD  = 3'd4
  } durSel_t;

  typedef struct packed {
    logic    load;
    durSel_t sel;
    logic    clrDirty;
    logic    wrOpen;
  } pathCtl_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvsc_path.sv
module nvsc_path
  import nvsc_pkg::*;
#(
  parameter int HOLD_CYC  = 3,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 5,
  parameter int CLEAR_CYC = 2,
  parameter int LOAD_CYC  = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  pathCtl_t ctl,
  input  logic     sramWrite,
  output logic     cntZero,
  output logic     dirty
);

  localparam int MAX_DUR = maxOf(maxOf(maxOf(HOLD_CYC, ERASE_CYC), maxOf(PROG_CYC, CLEAR_CYC)), LOAD_CYC);
  localparam int CNT_W   = $clog2(MAX_DUR + 1);
  localparam int NUM_DUR = 5;
  localparam int DUR_TAB [NUM_DUR] = '{HOLD_CYC, ERASE_CYC, PROG_CYC, CLEAR_CYC, LOAD_CYC};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal [NUM_DUR];

  for (genvar g = 0; g < NUM_DUR; g++) begin : g_dur
    assign loadVal[g] = CNT_W'(DUR_TAB[g] - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= loadVal[ctl.sel];
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirty <= 1'b0;
    end else if (ctl.clrDirty) begin
      dirty <= 1'b0;
    end else if (sramWrite && ctl.wrOpen) begin
      dirty <= 1'b1;
    end
  end

endmodule

// File: rtl/nvsc_ctrl.sv
module nvsc_ctrl
  import nvsc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinIn,
  input  logic                powerGood,
  input  logic                swStore,
  input  logic                swRecall,
  input  logic                cntZero,
  input  logic                dirty,
  output pathCtl_t            ctl,
  output logic                pinPullLow,
  output logic                readInhibit,
  output logic                writeInhibit,
  output logic                eraseEn,
  output logic                programEn,
  output logic                clearEn,
  output logic                loadEn,
  output logic [NUM_ST-1:0]   stateOneHot
);

  ctlState_t state, nextState;

  always_comb begin
    nextState    = state;
    ctl.load     = 1'b0;
    ctl.sel      = DUR_HOLD;
    ctl.clrDirty = 1'b0;
    if (!powerGood) begin
      nextState = ST_PWRLOSS;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!pinIn) begin
            if (dirty) begin
              nextState = ST_HOLDOFF;
              ctl.load  = 1'b1;
              ctl.sel   = DUR_HOLD;
            end else begin
              nextState = ST_BLOCKED;
            end
          end else if (swStore) begin
            nextState = ST_ERASE;
            ctl.load  = 1'b1;
            ctl.sel   = DUR_ERASE;
          end else if (swRecall) begin
            nextState = ST_CLEAR;
            ctl.load  = 1'b1;
            ctl.sel   = DUR_CLEAR;
          end
        end
        ST_HOLDOFF: if (cntZero) begin
          nextState = ST_ERASE;
          ctl.load  = 1'b1;
          ctl.sel   = DUR_ERASE;
        end
        ST_ERASE: if (cntZero) begin
          nextState = ST_PROGRAM;
          ctl.load  = 1'b1;
          ctl.sel   = DUR_PROG;
        end
        ST_PROGRAM: if (cntZero) begin
          nextState    = ST_RELEASE;
          ctl.clrDirty = 1'b1;
        end
        ST_CLEAR: if (cntZero) begin
          nextState = ST_LOAD;
          ctl.load  = 1'b1;
          ctl.sel   = DUR_LOAD;
        end
        ST_LOAD: if (cntZero) begin
          nextState    = ST_RELEASE;
          ctl.clrDirty = 1'b1;
        end
        ST_RELEASE, ST_BLOCKED: if (pinIn) nextState = ST_IDLE;
        ST_PWRLOSS: begin
          nextState = ST_CLEAR;
          ctl.load  = 1'b1;
          ctl.sel   = DUR_CLEAR;
        end
        default: nextState = ST_PWRLOSS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PWRLOSS;
    else       state <= nextState;
  end

  always_comb begin
    pinPullLow   = 1'b0;
    readInhibit  = 1'b1;
    writeInhibit = 1'b1;
    unique case (state)
      ST_IDLE: begin
        readInhibit  = 1'b0;
        writeInhibit = 1'b0;
      end
      ST_HOLDOFF: begin
        pinPullLow  = 1'b1;
        readInhibit = 1'b0;
      end
      ST_ERASE, ST_PROGRAM, ST_CLEAR, ST_LOAD: pinPullLow = 1'b1;
      default: pinPullLow = 1'b0;
    endcase
  end

  assign ctl.wrOpen  = !writeInhibit;
  assign eraseEn     = (state == ST_ERASE);
  assign programEn   = (state == ST_PROGRAM);
  assign clearEn     = (state == ST_CLEAR);
  assign loadEn      = (state == ST_LOAD);
  assign stateOneHot = NUM_ST'(1) << state;

endmodule

// File: rtl/nvshadow_arbiter.sv
module nvshadow_arbiter
  import nvsc_pkg::*;
#(
  parameter int HOLD_CYC  = 3,
  parameter int ERASE_CYC = 4,
  parameter int PROG_CYC  = 5,
  parameter int CLEAR_CYC = 2,
  parameter int LOAD_CYC  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       powerGood,
  input  logic       sramWrite,
  input  logic       swStore,
  input  logic       swRecall,
  output logic       pinPullLow,
  output logic       readInhibit,
  output logic       writeInhibit,
  output logic       eraseEn,
  output logic       programEn,
  output logic       clearEn,
  output logic       loadEn,
  output logic [8:0] stateOneHot
);

  pathCtl_t ctl;
  logic     cntZero;
  logic     dirty;

  nvsc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .powerGood(powerGood),
    .swStore(swStore), .swRecall(swRecall), .cntZero(cntZero), .dirty(dirty),
    .ctl(ctl), .pinPullLow(pinPullLow), .readInhibit(readInhibit),
    .writeInhibit(writeInhibit), .eraseEn(eraseEn), .programEn(programEn),
    .clearEn(clearEn), .loadEn(loadEn), .stateOneHot(stateOneHot)
  );

  nvsc_path #(
    .HOLD_CYC(HOLD_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .CLEAR_CYC(CLEAR_CYC), .LOAD_CYC(LOAD_CYC)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sramWrite(sramWrite),
    .cntZero(cntZero), .dirty(dirty)
  );

endmodule

// File: rtl/nvsc_chk.sv
module nvsc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pinIn,
  input logic       powerGood,
  input logic       pinPullLow,
  input logic       readInhibit,
  input logic       writeInhibit,
  input logic       eraseEn,
  input logic       programEn,
  input logic       clearEn,
  input logic       loadEn,
  input logic [8:0] stateOneHot
);

  p_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stateOneHot) == 1);

  p_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eraseEn, programEn, clearEn, loadEn}));

  p_pwrloss_r3: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> stateOneHot[8]);

  p_autorecall_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateOneHot[8] && powerGood) |=> stateOneHot[4]);

  p_holdoff_r5: assert property (@(posedge clk) disable iff (!rstN)
    stateOneHot[1] |-> (pinPullLow && writeInhibit && !readInhibit));

  p_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    stateOneHot[7] |-> (!pinPullLow && readInhibit && writeInhibit));

  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateOneHot[6] && pinIn && powerGood) |=> stateOneHot[0]);

  p_noqueue_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stateOneHot[2] || stateOneHot[3]) |=> !stateOneHot[4]);

endmodule

bind nvshadow_arbiter nvsc_chk u_chk (.*);

// File: tb/tb_nvshadow_arbiter.sv
`timescale 1ns/1ps
module tb_nvshadow_arbiter;

  localparam int DLY = 3, ER = 4, PR = 5, CL = 2, XF = 3, HOLD = 4;

  logic clk = 1'b0, rstN = 1'b0, powerGood = 1'b1;
  logic sramWrite = 1'b0, swStore = 1'b0, swRecall = 1'b0, extLow = 1'b0;
  logic pinIn, pinPullLow, readInhibit, writeInhibit;
  logic eraseEn, programEn, clearEn, loadEn;
  logic [8:0] stateOneHot;

  int nCmp = 0, nBad = 0, cycles = 0;
  int phaseCnt [9];

  always #4 clk = ~clk;

  assign pinIn = !(pinPullLow || extLow);

  nvshadow_arbiter #(.HOLD_CYC(DLY), .ERASE_CYC(ER), .PROG_CYC(PR),
                     .CLEAR_CYC(CL), .LOAD_CYC(XF)) dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .powerGood(powerGood),
    .sramWrite(sramWrite), .swStore(swStore), .swRecall(swRecall),
    .pinPullLow(pinPullLow), .readInhibit(readInhibit), .writeInhibit(writeInhibit),
    .eraseEn(eraseEn), .programEn(programEn), .clearEn(clearEn), .loadEn(loadEn),
    .stateOneHot(stateOneHot)
  );

  // cmd: 0 line low, 1 swStore, 2 swRecall, 3 both pulses, 4 line low plus swStore
  typedef struct packed {
    logic       mk;
    logic [2:0] cmd;
    logic [7:0] eHold, eErase, eProg, eClr, eLoad, eRel, eBlk;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 8'(DLY), 8'(ER), 8'(PR), 8'd0, 8'd0, 8'(HOLD), 8'd0},
    '{1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'(HOLD)},
    '{1'b0, 3'd1, 8'd0, 8'(ER), 8'(PR), 8'd0, 8'd0, 8'd1, 8'd0},
    '{1'b1, 3'd2, 8'd0, 8'd0, 8'd0, 8'(CL), 8'(XF), 8'd1, 8'd0},
    '{1'b0, 3'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'(HOLD)},
    '{1'b1, 3'd1, 8'd0, 8'(ER), 8'(PR), 8'd0, 8'd0, 8'd1, 8'd0},
    '{1'b0, 3'd3, 8'd0, 8'(ER), 8'(PR), 8'd0, 8'd0, 8'd1, 8'd0},
    '{1'b0, 3'd4, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'(HOLD)}
  };
  localparam string ROWTAG [NV] = '{"R5", "R6", "R7", "R8 R4", "R4 R6", "R7", "R10", "R10"};

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stIdx(input logic [8:0] s);
    int r = -1;
    for (int i = 0; i < 9; i++) if (s == 9'(1) << i) r = i;
    return r;
  endfunction

  function automatic string stTag(input int i);
    case (i)
      0: return "R10 idle outputs";
      1: return "R5 holdoff outputs";
      2, 3: return "R7 store outputs R12";
      4, 5: return "R8 recall outputs R12";
      6: return "R9 release outputs";
      7: return "R6 blocked outputs";
      8: return "R1 R3 powerloss outputs";
      default: return "R12 one-hot";
    endcase
  endfunction

  // expected {pull, rdInh, wrInh, erase, program, clear, load}
  function automatic logic [6:0] expOut(input int i);
    logic [6:0] e;
    case (i)
      0: e = 7'b000_0000;
      1: e = 7'b101_0000;
      2, 3, 4, 5: e = 7'b111_0000;
      default: e = 7'b011_0000;
    endcase
    if (i == 2) e[3] = 1'b1;
    if (i == 3) e[2] = 1'b1;
    if (i == 4) e[1] = 1'b1;
    if (i == 5) e[0] = 1'b1;
    return e;
  endfunction

  task automatic checkOutputs(input int i);
    check(stTag(i), int'({pinPullLow, readInhibit, writeInhibit, eraseEn, programEn, clearEn, loadEn}),
          (i < 0) ? 999 : int'(expOut(i)));
  endtask

  // counts negedge samples per state until idle; call just after a command was driven
  task automatic countPhases(input int holdN, input bit injWrite, input bit injSw);
    for (int i = 0; i < 9; i++) phaseCnt[i] = 0;
    for (int k = 0; k < 500; k++) begin
      int idx;
      @(negedge clk);
      swStore = 1'b0; swRecall = 1'b0; sramWrite = 1'b0;
      idx = stIdx(stateOneHot);
      if (idx == 0) break;
      if (idx < 0) begin
        check("R12 one-hot", int'(stateOneHot), 1);
        break;
      end
      phaseCnt[idx]++;
      checkOutputs(idx);
      if (injWrite && idx == 1 && phaseCnt[1] == 1) sramWrite = 1'b1;
      if (injSw && idx == 2 && phaseCnt[2] == 1) swRecall = 1'b1;
      if ((idx == 6 || idx == 7) && phaseCnt[idx] >= holdN) extLow = 1'b0;
    end
  endtask

  task automatic runOp(input logic mk, input logic [2:0] cmd, input bit injWrite, input bit injSw);
    if (mk) begin
      @(negedge clk); sramWrite = 1'b1;
      @(negedge clk); sramWrite = 1'b0;
    end
    @(negedge clk);
    case (cmd)
      3'd0: extLow = 1'b1;
      3'd1: swStore = 1'b1;
      3'd2: swRecall = 1'b1;
      3'd3: begin swStore = 1'b1; swRecall = 1'b1; end
      default: begin extLow = 1'b1; swStore = 1'b1; end
    endcase
    countPhases(HOLD, injWrite, injSw);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nCmp++; nBad++;
      $display("FAIL watchdog all requirements actual=%0d expected=%0d", cycles, 100000);
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 state", int'(stateOneHot), 256);
    check("R1 outputs", int'({pinPullLow, readInhibit, writeInhibit}), 3);
    rstN = 1'b1;
    // R2: automatic recall after reset with supply good
    countPhases(1, 1'b0, 1'b0);
    check("R2 clear cycles", phaseCnt[4], CL);
    check("R2 load cycles", phaseCnt[5], XF);
    check("R2 release cycles", phaseCnt[6], 1);

    for (int v = 0; v < NV; v++) begin
      runOp(VECS[v].mk, VECS[v].cmd, 1'b0, 1'b0);
      check({ROWTAG[v], " holdoff"}, phaseCnt[1], int'(VECS[v].eHold));
      check({ROWTAG[v], " erase"},   phaseCnt[2], int'(VECS[v].eErase));
      check({ROWTAG[v], " program"}, phaseCnt[3], int'(VECS[v].eProg));
      check({ROWTAG[v], " clear"},   phaseCnt[4], int'(VECS[v].eClr));
      check({ROWTAG[v], " load"},    phaseCnt[5], int'(VECS[v].eLoad));
      check({ROWTAG[v], " R9 release"}, phaseCnt[6], int'(VECS[v].eRel));
      check({ROWTAG[v], " blocked"}, phaseCnt[7], int'(VECS[v].eBlk));
    end

    // R4: write attempted during holdoff must not leave the latch set
    runOp(1'b1, 3'd0, 1'b1, 1'b0);
    check("R4 store ran", phaseCnt[3], PR);
    runOp(1'b0, 3'd0, 1'b0, 1'b0);
    check("R4 latch clear after blocked write (holdoff)", phaseCnt[1], 0);
    check("R4 latch clear after blocked write (blocked)", phaseCnt[7], HOLD);

    // R11: recall pulse during erase is ignored and not queued
    runOp(1'b0, 3'd1, 1'b0, 1'b1);
    check("R11 no clear", phaseCnt[4], 0);
    check("R11 no load", phaseCnt[5], 0);
    repeat (4) @(negedge clk);
    check("R11 stays idle", int'(stateOneHot), 1);

    // R3: supply drop mid-erase aborts, then recall runs on recovery
    @(negedge clk); swStore = 1'b1;
    @(negedge clk); swStore = 1'b0;
    @(negedge clk);
    check("R7 erase before drop", int'(stateOneHot), 4);
    powerGood = 1'b0;
    @(negedge clk);
    check("R3 powerloss state", int'(stateOneHot), 256);
    checkOutputs(stIdx(stateOneHot));
    @(negedge clk);
    check("R3 holds in powerloss", int'(stateOneHot), 256);
    powerGood = 1'b1;
    countPhases(1, 1'b0, 1'b0);
    check("R3 R2 no program after abort", phaseCnt[3], 0);
    check("R3 R2 clear cycles", phaseCnt[4], CL);
    check("R3 R2 load cycles", phaseCnt[5], XF);

    finishRun();
  end

endmodule